// File: doc/BRIEF.md
# Noise Quality Measurement Sequencer

This block runs a time-to-threshold noise measurement and turns the result into a 4-bit quality code. Before each run it holds an external integrating capacitor discharged. It then releases the capacitor and counts timebase ticks until an external comparator reports that the capacitor voltage has crossed its threshold. Noisy signals charge the capacitor fast, so a short time to threshold gives a high code (up to 15). A run that reaches the end of its window without a crossing gives 0.

A controller writes two control bits with a strobe: `cfg_cont` and `cfg_trig`. The settings are:

- **Trigger alone:** one measurement.
- **Both bits set:** free-running measurements, where each finished result overwrites the stored code.
- **Both bits clear:** stop. A run already under way finishes and its result is kept.
- **Continuous bit alone:** reserved, and the block ignores it.

The window is 16 bins of `TICKS_PER_BIN` ticks. With a timebase of 16·`TICKS_PER_BIN` ticks per 850 µs, the window never exceeds 850 µs.

Top module: `nqm_seq`

## Requirements
- R1: After reset `qual_code` is 0, `busy` and `trig_stat` are 0 and `cap_dump` is 1.
- R2: A strobed write with `cfg_cont`=0, `cfg_trig`=1 sets `trig_stat` at that edge, and `busy` rises at the next edge when the block was idle.
- R3: `trig_stat` reads 0 from the edge at which a measurement begins (capacitor discharge phase), unless a new trigger write lands on that same edge.
- R4: A measurement ends when `thr_hit` is sampled high. The stored code is 15 − floor(n / `TICKS_PER_BIN`), where n is the number of cycles with `tb_tick` high that elapsed while `cap_dump` was 0 before that cycle.
- R5: When 16·`TICKS_PER_BIN` ticks elapse without `thr_hit`, the measurement ends and the stored code is 0.
- R6: In single-shot mode, `busy` falls at the edge that ends the measurement, and `cap_dump` returns to 1.
- R7: A write with both bits set starts free-running operation. After each result `busy` stays 1 and a new discharge phase begins at once.
- R8: A write with both bits 0 lets a running measurement complete and store its code, after which the block goes idle.
- R9: A write with `cfg_cont`=1, `cfg_trig`=0 changes nothing: no start, no stop, `trig_stat` unchanged.
- R10: `qual_code` changes only at the end of a measurement. `thr_hit` and `tb_tick` outside a measurement have no effect.
- R11: `cap_dump` is held at 1 for `DUMP_CYC` cycles before every measurement, so it falls only while `busy` has already been 1.
- R12: In the cycle where `thr_hit` is high, a coincident `tb_tick` is not counted toward n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_cont | input | 1 | Continuous-mode control bit |
| cfg_trig | input | 1 | Trigger control bit |
| tb_tick | input | 1 | Timebase tick, one cycle wide |
| thr_hit | input | 1 | Comparator: capacitor crossed threshold |
| cap_dump | output | 1 | 1 = hold integrating capacitor discharged |
| qual_code | output | 4 | Stored quality code, 0 quiet to 15 noisy |
| trig_stat | output | 1 | Trigger bit readback, self-clearing |
| busy | output | 1 | Measurement sequence in progress |

## Verification
The timing of each result after its stimulus is as follows:

- `trig_stat` is due one edge after the write.
- `busy` is due one edge after that.
- The fall of `cap_dump` is due `DUMP_CYC` edges later.
- `qual_code` is due at the very edge that samples `thr_hit` or the final tick.

The bench drives inputs and reads outputs on falling edges. It counts its own ticks only in cycles whose preceding falling-edge sample showed `cap_dump` low. It then checks the code at the falling edge right after the ending cycle, and checks `busy` and `trig_stat` at the falling edges one and two cycles after a write.

// File: rtl/nqm_pkg.sv
package nqm_pkg;

  localparam int QW = 4;
  localparam int unsigned QMAX = (1 << QW) - 1;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_DUMP = 2'd1,
    SQ_MEAS = 2'd2
  } sq_state_e;

  // Elapsed ticks to quality code: earlier crossing means more noise.
  function automatic logic [QW-1:0] quant_code(input int unsigned elapsed,
                                               input int unsigned per_bin);
    int unsigned bin;
    logic [QW-1:0] code;
    bin = elapsed / per_bin;
    if (bin > QMAX) code = '0;
    else            code = QW'(QMAX - bin);
    return code;
  endfunction

endpackage

// File: rtl/nqm_ctl.sv
module nqm_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_cont,
  input  logic cfg_trig,
  input  logic meas_begin,
  output logic cont_mode,
  output logic trig_pend
);

  logic wr_start;
  logic wr_stop;

  // Continuous-only combination is reserved: it decodes to nothing.
  assign wr_start = cfg_wr && cfg_trig;
  assign wr_stop  = cfg_wr && !cfg_cont && !cfg_trig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cont_mode <= 1'b0;
      trig_pend <= 1'b0;
    end else if (wr_start) begin
      cont_mode <= cfg_cont;
      trig_pend <= 1'b1;
    end else if (wr_stop) begin
      cont_mode <= 1'b0;
      trig_pend <= 1'b0;
    end else if (meas_begin) begin
      trig_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/nqm_fsm.sv
module nqm_fsm #(
  parameter int DUMP_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  input  logic cont_mode,
  input  logic fin_ev,
  output logic meas_begin,
  output logic meas_on,
  output logic busy,
  output logic cap_dump
);
  import nqm_pkg::*;

  localparam int DW = (DUMP_CYC > 1) ? $clog2(DUMP_CYC) : 1;
  localparam logic [DW-1:0] DUMP_LAST = DW'(DUMP_CYC - 1);

  sq_state_e st, nxt;
  logic [DW-1:0] dcnt;

  always_comb begin
    nxt        = st;
    meas_begin = 1'b0;
    case (st)
      SQ_IDLE: begin
        if (go_req) begin
          nxt        = SQ_DUMP;
          meas_begin = 1'b1;
        end
      end
      SQ_DUMP: begin
        if (dcnt == DUMP_LAST) nxt = SQ_MEAS;
      end
      SQ_MEAS: begin
        if (fin_ev) begin
          if (cont_mode || go_req) begin
            nxt        = SQ_DUMP;
            meas_begin = 1'b1;
          end else begin
            nxt = SQ_IDLE;
          end
        end
      end
      default: nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SQ_IDLE;
      dcnt <= '0;
    end else begin
      st <= nxt;
      if (st == SQ_DUMP && nxt == SQ_DUMP) dcnt <= dcnt + DW'(1);
      else                                 dcnt <= '0;
    end
  end

  assign meas_on  = (st == SQ_MEAS);
  assign busy     = (st != SQ_IDLE);
  assign cap_dump = (st != SQ_MEAS);

endmodule

// File: rtl/nqm_timer.sv
module nqm_timer #(
  parameter int TICKS_PER_BIN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   meas_on,
  input  logic                   tb_tick,
  input  logic                   thr_hit,
  output logic                   fin_ev,
  output logic                   timeout_ev,
  output logic [nqm_pkg::QW-1:0] qual_code
);
  import nqm_pkg::*;

  localparam int WINDOW = TICKS_PER_BIN * (1 << QW);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] T_LAST = CW'(WINDOW - 1);

  logic [CW-1:0] tcnt;
  logic          at_last;

  assign at_last    = (tcnt == T_LAST);
  assign timeout_ev = meas_on && !thr_hit && tb_tick && at_last;
  assign fin_ev     = meas_on && (thr_hit || (tb_tick && at_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
    end else if (!meas_on) begin
      tcnt <= '0;
    end else if (tb_tick && !thr_hit) begin
      tcnt <= tcnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual_code <= '0;
    end else if (fin_ev) begin
      qual_code <= thr_hit ? quant_code(32'(tcnt), TICKS_PER_BIN) : '0;
    end
  end

endmodule

// File: rtl/nqm_seq.sv
module nqm_seq #(
  parameter int TICKS_PER_BIN = 4,
  parameter int DUMP_CYC      = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic                   cfg_cont,
  input  logic                   cfg_trig,
  input  logic                   tb_tick,
  input  logic                   thr_hit,
  output logic                   cap_dump,
  output logic [nqm_pkg::QW-1:0] qual_code,
  output logic                   trig_stat,
  output logic                   busy
);

  logic cont_mode;
  logic trig_pend;
  logic meas_begin;
  logic meas_on;
  logic fin_ev;
  logic timeout_ev;

  nqm_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_cont  (cfg_cont),
    .cfg_trig  (cfg_trig),
    .meas_begin(meas_begin),
    .cont_mode (cont_mode),
    .trig_pend (trig_pend)
  );

  nqm_fsm #(.DUMP_CYC(DUMP_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_req    (trig_pend),
    .cont_mode (cont_mode),
    .fin_ev    (fin_ev),
    .meas_begin(meas_begin),
    .meas_on   (meas_on),
    .busy      (busy),
    .cap_dump  (cap_dump)
  );

  nqm_timer #(.TICKS_PER_BIN(TICKS_PER_BIN)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .meas_on   (meas_on),
    .tb_tick   (tb_tick),
    .thr_hit   (thr_hit),
    .fin_ev    (fin_ev),
    .timeout_ev(timeout_ev),
    .qual_code (qual_code)
  );

  assign trig_stat = trig_pend;

endmodule

// File: rtl/nqm_seq_chk.sv
module nqm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       cfg_cont,
  input logic       cfg_trig,
  input logic       cap_dump,
  input logic [3:0] qual_code,
  input logic       trig_stat,
  input logic       busy,
  input logic       cont_mode,
  input logic       meas_begin,
  input logic       fin_ev,
  input logic       timeout_ev
);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_trig |=> trig_stat);

  p_trig_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    meas_begin && !cfg_wr |=> !trig_stat);

  p_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_ev |=> qual_code == 4'd0);

  p_single_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ev && !cont_mode && !trig_stat && !cfg_wr |=> !busy && cap_dump);

  p_cont_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ev && cont_mode && !cfg_wr |=> busy && cap_dump);

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_cont && !cfg_trig && !busy && !trig_stat |=> !busy && !trig_stat);

  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_ev |=> $stable(qual_code));

  p_dump_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_dump) |-> busy && $past(busy));

endmodule

bind nqm_seq nqm_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_cont  (cfg_cont),
  .cfg_trig  (cfg_trig),
  .cap_dump  (cap_dump),
  .qual_code (qual_code),
  .trig_stat (trig_stat),
  .busy      (busy),
  .cont_mode (cont_mode),
  .meas_begin(meas_begin),
  .fin_ev    (fin_ev),
  .timeout_ev(timeout_ev)
);

// File: tb/nqm_seq_bench.sv
module nqm_seq_bench;

  localparam int TPB    = 4;
  localparam int DCYC   = 2;
  localparam int WINDOW = TPB * 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_cont = 1'b0, cfg_trig = 1'b0;
  logic       tb_tick = 1'b0, thr_hit = 1'b0;
  logic       cap_dump, trig_stat, busy;
  logic [3:0] qual_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  nqm_seq #(.TICKS_PER_BIN(TPB), .DUMP_CYC(DCYC)) u_nqm_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_cont(cfg_cont),
    .cfg_trig(cfg_trig), .tb_tick(tb_tick), .thr_hit(thr_hit),
    .cap_dump(cap_dump), .qual_code(qual_code), .trig_stat(trig_stat),
    .busy(busy)
  );

  // Bench model of the code: step down one level per full bin.
  function automatic int exp_code(int n);
    int c = 15;
    int lim = TPB;
    if (n >= WINDOW) return 0;
    while (n >= lim && c > 0) begin
      c--;
      lim += TPB;
    end
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(bit c, bit t);
    tb_tick = 1'b0; thr_hit = 1'b0;
    cfg_wr = 1'b1; cfg_cont = c; cfg_trig = t;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_cont = 1'b0; cfg_trig = 1'b0;
  endtask

  task automatic wait_meas();
    for (int i = 0; i < 40 && cap_dump; i++) @(negedge clk);
    chk(!cap_dump && busy, "R11", int'(cap_dump), 0);
  endtask

  // Runs one measurement from its first cycle; returns the expected code.
  task automatic run_meas(int target, bit rnd, bit tick_on_hit, output int exp);
    int cnt = 0;
    exp = exp_code(target);
    for (int g = 0; g < 4 * WINDOW; g++) begin
      if (cnt == target && target < WINDOW) begin
        thr_hit = 1'b1;
        tb_tick = tick_on_hit ? 1'b1 : (rnd ? 1'($urandom_range(1, 0)) : 1'b1);
        @(negedge clk);
        thr_hit = 1'b0; tb_tick = 1'b0;
        return;
      end
      tb_tick = rnd ? 1'($urandom_range(1, 0)) : 1'b1;
      @(negedge clk);
      if (tb_tick) cnt++;
      tb_tick = 1'b0;
      if (cap_dump) begin
        exp = 0;
        return;
      end
    end
  endtask

  task automatic single(int target, bit rnd, bit toh, string req);
    int e;
    do_write(1'b0, 1'b1);
    chk(trig_stat == 1'b1, "R2", int'(trig_stat), 1);
    @(negedge clk);
    chk(busy == 1'b1, "R2", int'(busy), 1);
    chk(trig_stat == 1'b0, "R3", int'(trig_stat), 0);
    wait_meas();
    run_meas(target, rnd, toh, e);
    chk(qual_code == 4'(e), req, int'(qual_code), e);
    chk(!busy && cap_dump, "R6", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(qual_code == 4'd0, "R1", int'(qual_code), 0);
    chk(cap_dump && !busy && !trig_stat, "R1", int'(busy), 0);

    // R10: idle stimulus has no effect
    for (int i = 0; i < 10; i++) begin
      thr_hit = 1'(i & 1); tb_tick = 1'b1;
      @(negedge clk);
    end
    thr_hit = 1'b0; tb_tick = 1'b0;
    chk(qual_code == 4'd0 && !busy, "R10", int'(qual_code), 0);

    // R9: reserved write in idle
    do_write(1'b1, 1'b0);
    chk(trig_stat == 1'b0, "R9", int'(trig_stat), 0);
    @(negedge clk);
    chk(busy == 1'b0, "R9", int'(busy), 0);

    // Directed single shots
    single(0, 1'b0, 1'b0, "R4");
    single(WINDOW + 5, 1'b0, 1'b0, "R5");
    single(TPB - 1, 1'b0, 1'b1, "R12");
    single(5, 1'b0, 1'b0, "R4");
    single(WINDOW - 1, 1'b0, 1'b0, "R4");

    // R10: result held while idle with stray inputs
    for (int i = 0; i < 20; i++) begin
      thr_hit = 1'($urandom_range(1, 0)); tb_tick = 1'($urandom_range(1, 0));
      @(negedge clk);
    end
    thr_hit = 1'b0; tb_tick = 1'b0;
    chk(qual_code == 4'(exp_code(WINDOW - 1)), "R10", int'(qual_code), exp_code(WINDOW - 1));

    // Random single shots
    for (int i = 0; i < 20; i++)
      single(int'($urandom_range(WINDOW + 3, 0)), 1'b1, 1'b0, "R4");

    // R7: continuous operation
    do_write(1'b1, 1'b1);
    chk(trig_stat == 1'b1, "R2", int'(trig_stat), 1);
    for (int i = 0; i < 6; i++) begin
      wait_meas();
      if (i == 2) begin
        do_write(1'b1, 1'b0);   // reserved: must not stop free-running
      end
      run_meas(int'($urandom_range(WINDOW + 2, 0)), 1'b1, 1'b0, e);
      chk(qual_code == 4'(e), "R7", int'(qual_code), e);
      chk(busy && cap_dump, (i == 2) ? "R9" : "R7", int'(busy), 1);
    end

    // R8: stop during a running measurement
    wait_meas();
    do_write(1'b0, 1'b0);
    chk(busy == 1'b1, "R8", int'(busy), 1);
    run_meas(7, 1'b0, 1'b0, e);
    chk(qual_code == 4'(e), "R8", int'(qual_code), e);
    chk(!busy, "R8", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk(!busy && !trig_stat, "R8", int'(busy), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule